// File: doc/BRIEF.md
# Charger Input Source Selector

This block decides which supply feeds a single-cell battery charger and which current limit applies to it. It receives two digital presence flags from external comparators, one saying the wall adapter voltage is above the battery voltage and one saying the USB bus voltage is above the battery voltage. It also receives the host's rate-select pin, which has three levels and arrives already decoded into two bits.

Each presence flag first passes through a deglitch filter. The filter is timed by a slow tick strobe, and a new flag level is accepted only after it has held for `DEG_TICKS` consecutive ticks. The filtered flags drive a registered arbiter in which the adapter always wins. From the chosen source the block derives a current-limit code, a sleep request for the case where neither supply is present, and an active-low power-good flag that reports only a valid adapter. Every change of source raises a one-cycle pulse so that the charge sequencer can restart its phase.

Top module: `chg_src_sel`

## Requirements
- R1: When the filtered adapter flag is set, `src_sel_o` is 1 (adapter), whatever the USB flag is.
- R2: When the filtered adapter flag is clear and the filtered USB flag is set, `src_sel_o` is 2 (USB).
- R3: With USB selected and `rate_sel_i` = 2'b00 (pin driven low), `ilim_code_o` is 2 (100 mA).
- R4: With USB selected and `rate_sel_i` = 2'b01 (pin driven high), `ilim_code_o` is 3 (500 mA).
- R5: With USB selected and `rate_sel_i` = 2'b10 (pin floating) or the unused code 2'b11, `ilim_code_o` is 0 (no charging).
- R6: With the adapter selected, `ilim_code_o` is 1 (resistor-set limit), whatever `rate_sel_i` is.
- R7: When both filtered flags are clear, `src_sel_o` is 0 (none), `sleep_req_o` is 1 and `pgood_n_o` is 1.
- R8: `pgood_n_o` is 0 exactly when the adapter is the selected source.
- R9: A raw flag level that differs from the filtered level is accepted only after it has been seen on `DEG_TICKS` consecutive ticks. If the raw flag returns to the filtered level first, the count restarts.
- R10: `src_chg_o` is high for exactly one cycle, and that cycle is the first one in which `src_sel_o` shows a new value.
- R11: During and right after reset, `src_sel_o` is 0, `ilim_code_o` is 0, `sleep_req_o` is 1, `pgood_n_o` is 1 and `src_chg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Deglitch timebase strobe, one cycle wide |
| adp_above_bat_i | input | 1 | Raw comparator flag: adapter voltage above battery |
| usb_above_bat_i | input | 1 | Raw comparator flag: USB voltage above battery |
| rate_sel_i | input | 2 | Decoded rate pin: 00 low, 01 high, 10 floating, 11 unused |
| src_sel_o | output | 2 | Selected source: 0 none, 1 adapter, 2 USB |
| ilim_code_o | output | 2 | Limit: 0 none, 1 resistor-set, 2 100 mA, 3 500 mA |
| sleep_req_o | output | 1 | High when no supply is present |
| pgood_n_o | output | 1 | Active-low adapter power-good |
| src_chg_o | output | 1 | One-cycle pulse on every change of source |

## Verification
The bench applies both supplies together and checks that the adapter still wins. A design that gave USB priority would select source 2 and take its limit from the rate pin. It also changes the rate pin while the adapter is in use. If the pin leaked into adapter mode, the limit code would move away from 1.

The floating and unused rate codes are both driven with USB selected. A decoder that treated the unused code as a valid rate would report a nonzero limit. A supply glitch shorter than the filter window is applied and then removed. A filter that did not restart its count, or that accepted on the first tick, would switch the source and raise a spurious change pulse. The bench counts the high cycles of the change pulse on each transition, which catches a pulse that is stretched or missing.

// File: rtl/chg_src_pkg.sv
package chg_src_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ADP  = 2'd1,
    SRC_USB  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ILIM_OFF    = 2'd0,
    ILIM_RSET   = 2'd1,
    ILIM_USB100 = 2'd2,
    ILIM_USB500 = 2'd3
  } ilim_e;

  localparam logic [1:0] RATE_LOW  = 2'b00;
  localparam logic [1:0] RATE_HIGH = 2'b01;
  localparam logic [1:0] RATE_HIZ  = 2'b10;
endpackage

// File: rtl/chg_src_deglitch.sv
module chg_src_deglitch #(
  parameter int DEG_TICKS = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(DEG_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= LAST) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/chg_src_arbiter.sv
module chg_src_arbiter
  import chg_src_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adp_ok_i,
  input  logic usb_ok_i,
  output src_e src_o,
  output logic chg_o
);
  src_e src_q, src_d;
  logic chg_q;

  always_comb begin
    if (adp_ok_i)      src_d = SRC_ADP;
    else if (usb_ok_i) src_d = SRC_USB;
    else               src_d = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      chg_q <= 1'b0;
    end else begin
      src_q <= src_d;
      chg_q <= (src_d != src_q);
    end
  end

  assign src_o = src_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/chg_src_limit.sv
module chg_src_limit
  import chg_src_pkg::*;
(
  input  src_e        src_i,
  input  logic [1:0]  rate_i,
  output ilim_e       ilim_o,
  output logic        sleep_o,
  output logic        pgood_n_o
);
  always_comb begin
    ilim_o = ILIM_OFF;
    unique case (src_i)
      SRC_ADP: ilim_o = ILIM_RSET;
      SRC_USB: begin
        if (rate_i == RATE_LOW)       ilim_o = ILIM_USB100;
        else if (rate_i == RATE_HIGH) ilim_o = ILIM_USB500;
        else                          ilim_o = ILIM_OFF;
      end
      default: ilim_o = ILIM_OFF;
    endcase
  end

  assign sleep_o   = (src_i == SRC_NONE);
  assign pgood_n_o = (src_i != SRC_ADP);
endmodule

// File: rtl/chg_src_sel.sv
module chg_src_sel
  import chg_src_pkg::*;
#(
  parameter int DEG_TICKS = 375
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       adp_above_bat_i,
  input  logic       usb_above_bat_i,
  input  logic [1:0] rate_sel_i,
  output logic [1:0] src_sel_o,
  output logic [1:0] ilim_code_o,
  output logic       sleep_req_o,
  output logic       pgood_n_o,
  output logic       src_chg_o
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] raw_flags;
  logic [NFLAG-1:0] filt_flags;
  src_e             src;
  ilim_e            ilim;

  assign raw_flags = {usb_above_bat_i, adp_above_bat_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_deg
    chg_src_deglitch #(.DEG_TICKS(DEG_TICKS)) u_deg (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .raw_i  (raw_flags[g]),
      .filt_o (filt_flags[g])
    );
  end

  chg_src_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .adp_ok_i (filt_flags[0]),
    .usb_ok_i (filt_flags[1]),
    .src_o    (src),
    .chg_o    (src_chg_o)
  );

  chg_src_limit u_lim (
    .src_i     (src),
    .rate_i    (rate_sel_i),
    .ilim_o    (ilim),
    .sleep_o   (sleep_req_o),
    .pgood_n_o (pgood_n_o)
  );

  assign src_sel_o   = src;
  assign ilim_code_o = ilim;
endmodule

// File: rtl/chg_src_sel_chk.sv
module chg_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [1:0] rate_sel_i,
  input logic [1:0] src_sel_o,
  input logic [1:0] ilim_code_o,
  input logic       sleep_req_o,
  input logic       pgood_n_o,
  input logic       src_chg_o
);
  AST_ADP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_o == 2'd1 |-> ilim_code_o == 2'd1); // R6
  AST_USB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_o == 2'd2 && rate_sel_i == 2'b00) |-> ilim_code_o == 2'd2); // R3
  AST_USB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_o == 2'd2 && rate_sel_i == 2'b01) |-> ilim_code_o == 2'd3); // R4
  AST_USB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_o == 2'd2 && rate_sel_i[1]) |-> ilim_code_o == 2'd0); // R5
  AST_SLEEP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req_o |-> (src_sel_o == 2'd0 && pgood_n_o)); // R7
  AST_PGOOD_ADP: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_n_o |-> src_sel_o == 2'd1); // R8
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel_o) |-> $past(tick_i, 2)); // R9
  AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg_o |=> !src_chg_o); // R10
  AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel_o) |-> src_chg_o); // R10
endmodule

bind chg_src_sel chg_src_sel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .rate_sel_i  (rate_sel_i),
  .src_sel_o   (src_sel_o),
  .ilim_code_o (ilim_code_o),
  .sleep_req_o (sleep_req_o),
  .pgood_n_o   (pgood_n_o),
  .src_chg_o   (src_chg_o)
);

// File: tb/chg_src_sel_tb_top.sv
`timescale 1ns/1ps
module chg_src_sel_tb_top;
  localparam int DEG = 4;
  localparam int TDIV = 4;
  localparam int SETTLE = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       adp = 1'b0;
  logic       usb = 1'b0;
  logic [1:0] rate = 2'b00;
  logic [1:0] src_sel, ilim;
  logic       sleep_req, pgood_n, src_chg;

  int n_chk = 0;
  int n_bad = 0;
  int chg_hi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chg_src_sel #(.DEG_TICKS(DEG)) dut_i (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i),
    .adp_above_bat_i (adp), .usb_above_bat_i (usb), .rate_sel_i (rate),
    .src_sel_o (src_sel), .ilim_code_o (ilim), .sleep_req_o (sleep_req),
    .pgood_n_o (pgood_n), .src_chg_o (src_chg)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick_i = (div == TDIV - 1);
      div = (div + 1) % TDIV;
    end
  end

  initial forever begin
    @(negedge clk);
    if (src_chg) chg_hi++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 src", src_sel, 0);
    chk("R11 ilim", ilim, 0);
    chk("R11 sleep", sleep_req, 1);
    chk("R11 pgood_n", pgood_n, 1);
    chk("R11 chg", src_chg, 0);
  endtask

  task automatic t_adapter_only();
    int c0 = chg_hi;
    adp = 1'b1; usb = 1'b0; rate = 2'b01;
    settle();
    chk("R1 src", src_sel, 1);
    chk("R6 ilim", ilim, 1);
    chk("R8 pgood_n", pgood_n, 0);
    chk("R10 pulse cycles", chg_hi - c0, 1);
  endtask

  task automatic t_both_present();
    usb = 1'b1;
    settle();
    chk("R1 adapter wins", src_sel, 1);
    rate = 2'b00; @(negedge clk);
    chk("R6 rate ignored low", ilim, 1);
    rate = 2'b10; @(negedge clk);
    chk("R6 rate ignored hiz", ilim, 1);
    chk("R7 no sleep", sleep_req, 0);
  endtask

  task automatic t_usb_rates();
    int c0 = chg_hi;
    adp = 1'b0; rate = 2'b00;
    settle();
    chk("R2 src", src_sel, 2);
    chk("R10 pulse cycles", chg_hi - c0, 1);
    chk("R8 pgood_n usb", pgood_n, 1);
    chk("R3 ilim 100", ilim, 2);
    rate = 2'b01; @(negedge clk);
    chk("R4 ilim 500", ilim, 3);
    rate = 2'b10; @(negedge clk);
    chk("R5 ilim hiz", ilim, 0);
    rate = 2'b11; @(negedge clk);
    chk("R5 ilim unused", ilim, 0);
    chk("R5 still usb", src_sel, 2);
  endtask

  task automatic t_none();
    usb = 1'b0;
    settle();
    chk("R7 src", src_sel, 0);
    chk("R7 sleep", sleep_req, 1);
    chk("R7 pgood_n", pgood_n, 1);
    chk("R7 ilim", ilim, 0);
  endtask

  task automatic t_glitch();
    int c0 = chg_hi;
    adp = 1'b1;
    repeat ((DEG - 2) * TDIV) @(negedge clk);
    adp = 1'b0;
    settle();
    chk("R9 glitch rejected", src_sel, 0);
    chk("R9 no pulse", chg_hi - c0, 0);
    adp = 1'b1;
    repeat ((DEG - 2) * TDIV) @(negedge clk);
    chk("R9 not yet accepted", src_sel, 0);
    settle();
    chk("R9 accepted", src_sel, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_adapter_only();
    t_both_present();
    t_usb_rates();
    t_none();
    t_glitch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule